// File: doc/BRIEF.md
# Distribution-shaped random tap-code source

This block emits a stream of 5-bit delay-tap codes whose values follow a distribution chosen by the host. A five-stage Galois shift register produces a pseudorandom index. The index, joined with a bank number, addresses a pattern memory. Each memory word is one tap code. A bank holds one shape table, for example a Gaussian, a dual-impulse, a sinusoidal or a truncated Gaussian histogram. The host fills a table so that each code appears in proportion to its wanted probability. The uniformly random index then yields codes with that shape.

Codes leave through a valid/ready output. A code is held, and the shift register does not move, while `tap_valid` is high and `tap_ready` is low. New codes enter the pipeline only on cycles where `step_en` is high. The host loads tables through a plain write port. The port works only while `step_en` is low, so a table is never rewritten while it is being read.

Top module: `pdf_tap_selector`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `tap_valid` is 0. Reset loads the shift-register state with the seed 5'b00001.
- R2: On each advance the state s becomes (s >> 1) XOR (s[0] ? 5'b10100 : 5'b00000). The state is never zero and repeats with period 31. From the seed, the first state after an advance is 5'b10100 (decimal 20).
- R3: The read address is {bank, state}. The bank number is in the upper 5 bits and the state is in the lower 5 bits. `bank_sel` is captured on the same edge as the advance it belongs to.
- R4: An advance happens on an edge where `step_en` is high and the output is not stalled. On the following edge, `tap_code` takes the memory word at the new state's address, and `tap_valid` is 1.
- R5: While `tap_valid` is 1 and `tap_ready` is 0, `tap_code` and `tap_valid` stay stable and the shift register does not advance. No code is lost or skipped.
- R6: A write with `host_we` high stores `host_data` at `host_addr`, using the same {bank, index} layout as R3, only when `step_en` is low. A write attempted while `step_en` is high leaves the memory unchanged.
- R7: While `step_en` is low, the state holds. `tap_valid` falls once the in-flight code has been accepted. Streaming resumes with the next state in sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Request a new code on this edge |
| bank_sel | input | 5 | Active shape table |
| host_we | input | 1 | Table write strobe |
| host_addr | input | 10 | Table write address {bank, index} |
| host_data | input | 5 | Tap code to store |
| tap_ready | input | 1 | Consumer accepts `tap_code` |
| tap_code | output | 5 | Selected delay tap |
| tap_valid | output | 1 | `tap_code` holds a fresh code |

## Verification
Assertions check several properties on every cycle. The shift-register state is never zero. The state holds on any edge without an advance. A stalled output stays frozen. Every issued read yields a valid code on the next edge. The bench scenarios cover the rest: the exact state sequence and its 31-step period, the placement of bank and index in the address, the point at which a bank switch takes effect, and the rejection of writes during streaming. Each of these shows only in the code values at the port, measured against a table the bench loaded itself.

// File: rtl/pdf_sel_pkg.sv
package pdf_sel_pkg;
  localparam int unsigned CODE_W_DEF = 5;
  localparam int unsigned IDX_W_DEF  = 5;
  localparam int unsigned BANK_W_DEF = 5;
  localparam logic [4:0]  MASK_DEF   = 5'b10100;
  localparam logic [4:0]  SEED_DEF   = 5'b00001;
endpackage

// File: rtl/tap_lfsr.sv
module tap_lfsr #(
  parameter int unsigned W    = pdf_sel_pkg::IDX_W_DEF,
  parameter logic [W-1:0] MASK = pdf_sel_pkg::MASK_DEF,
  parameter logic [W-1:0] SEED = pdf_sel_pkg::SEED_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] shifted;
  logic [W-1:0] nxt;

  always_comb begin
    shifted = state_q >> 1;
    if (state_q == '0)       nxt = SEED;
    else if (state_q[0])     nxt = shifted ^ MASK;
    else                     nxt = shifted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   state_q <= SEED;
    else if (adv) state_q <= nxt;
  end

  assign state = state_q;

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R7
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));
endmodule

// File: rtl/shape_ram.sv
module shape_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/pdf_tap_selector.sv
module pdf_tap_selector #(
  parameter int unsigned CODE_W = pdf_sel_pkg::CODE_W_DEF,
  parameter int unsigned IDX_W  = pdf_sel_pkg::IDX_W_DEF,
  parameter int unsigned BANK_W = pdf_sel_pkg::BANK_W_DEF,
  parameter logic [IDX_W-1:0] MASK = pdf_sel_pkg::MASK_DEF,
  parameter logic [IDX_W-1:0] SEED = pdf_sel_pkg::SEED_DEF,
  localparam int unsigned AW = BANK_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [CODE_W-1:0] host_data,
  input  logic              tap_ready,
  output logic [CODE_W-1:0] tap_code,
  output logic              tap_valid
);
  logic              stall;
  logic              adv;
  logic              fire_q;
  logic [BANK_W-1:0] bank_q;
  logic [IDX_W-1:0]  idx;
  logic              valid_q;

  assign stall = valid_q && !tap_ready;
  assign adv   = step_en && !stall;

  tap_lfsr #(.W(IDX_W), .MASK(MASK), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .state(idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_q  <= 1'b0;
      bank_q  <= '0;
      valid_q <= 1'b0;
    end else if (!stall) begin
      fire_q  <= step_en;
      if (step_en) bank_q <= bank_sel;
      valid_q <= fire_q;
    end
  end

  shape_ram #(.AW(AW), .DW(CODE_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_we && !step_en), .wr_addr(host_addr), .wr_data(host_data),
    .rd_en(fire_q && !stall), .rd_addr({bank_q, idx}), .rd_q(tap_code)
  );

  assign tap_valid = valid_q;

  // R5
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (tap_valid && $stable(tap_code)));
  // R4
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !stall) |=> tap_valid);
endmodule

// File: tb/sim_pdf_tap_selector.sv
`timescale 1ns/1ps
module sim_pdf_tap_selector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0;
  logic [4:0] bank_sel = '0;
  logic host_we = 1'b0;
  logic [9:0] host_addr = '0;
  logic [4:0] host_data = '0;
  logic tap_ready = 1'b1;
  logic [4:0] tap_code;
  logic tap_valid;

  always #2.5 clk = ~clk;

  pdf_tap_selector u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .bank_sel(bank_sel),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .tap_ready(tap_ready), .tap_code(tap_code), .tap_valid(tap_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [4:0] m_mem [1024];
  logic [4:0] m_s = 5'b00001;
  logic       m_fire = 1'b0;
  logic [4:0] m_bank = '0;
  logic       m_valid = 1'b0;
  logic [4:0] m_code = '0;

  function automatic logic [4:0] nxt(input logic [4:0] s);
    return s[0] ? ((s >> 1) ^ 5'b10100) : (s >> 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive, update model, sample after the edge
  task automatic cyc(input logic en, input logic rdy, input logic [4:0] bank,
                     input logic we, input logic [9:0] a, input logic [4:0] d,
                     input string req);
    logic stall;
    step_en = en; tap_ready = rdy; bank_sel = bank;
    host_we = we; host_addr = a; host_data = d;
    stall = m_valid && !rdy;
    if (we && !en) m_mem[a] = d;
    if (!stall) begin
      if (m_fire) m_code = m_mem[{m_bank, m_s}];
      m_valid = m_fire;
      m_fire  = en;
      if (en) begin m_s = nxt(m_s); m_bank = bank; end
    end
    @(posedge clk); #1;
    check(req, tap_valid, m_valid);
    if (m_valid) check(req, tap_code, m_code);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1", tap_valid, 0);
    rst_n = 1'b1;
    m_s = 5'b00001; m_fire = 0; m_valid = 0; m_bank = 0;
    @(posedge clk); #1;
    check("R1", tap_valid, 0);
  endtask

  task automatic t_load;
    for (int i = 0; i < 32; i++) begin
      cyc(0, 1, 0, 1, {5'd0, 5'(i)}, 5'(i), "R6");
      cyc(0, 1, 0, 1, {5'd5, 5'(i)}, 5'(31 - i), "R6");
      cyc(0, 1, 0, 1, {5'd9, 5'(i)}, 5'((i * 7) & 31), "R6");
    end
  endtask

  task automatic t_sequence;
    logic [4:0] seen [62];
    int n = 0;
    cyc(1, 1, 0, 0, 0, 0, "R4");
    check("R4", tap_valid, 0);
    cyc(1, 1, 0, 0, 0, 0, "R4");
    check("R2", tap_code, 20);
    while (n < 62) begin
      if (tap_valid) begin
        seen[n] = tap_code;
        n++;
      end
      if (n < 62) cyc(1, 1, 0, 0, 0, 0, "R2");
    end
    for (int i = 0; i < 31; i++) begin
      check("R2", seen[i] == 0, 0);
      check("R2", seen[i], seen[i + 31]);
    end
  endtask

  task automatic t_banks;
    for (int i = 0; i < 12; i++) cyc(1, 1, 5, 0, 0, 0, "R3");
    for (int i = 0; i < 12; i++) cyc(1, 1, 9, 0, 0, 0, "R3");
    for (int i = 0; i < 6; i++)  cyc(1, 1, 5'(i), 0, 0, 0, "R3");
  endtask

  task automatic t_stall;
    logic [4:0] held;
    cyc(1, 1, 5, 0, 0, 0, "R5");
    held = tap_code;
    for (int i = 0; i < 5; i++) begin
      cyc(1, 0, 5, 0, 0, 0, "R5");
      check("R5", tap_code, held);
    end
    for (int i = 0; i < 6; i++) cyc(1, 1, 5, 0, 0, 0, "R5");
  endtask

  task automatic t_ignore;
    for (int i = 0; i < 32; i++) cyc(1, 1, 9, 1, {5'd9, 5'(i)}, 5'd3, "R6");
    for (int i = 0; i < 34; i++) cyc(1, 1, 9, 0, 0, 0, "R6");
  endtask

  task automatic t_idle;
    cyc(0, 1, 0, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, 0, 0, "R7");
    check("R7", tap_valid, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, 0, 0, "R7");
    check("R7", tap_valid, 0);
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, 0, "R7");
  endtask

  initial begin
    t_reset;
    t_load;
    t_sequence;
    t_banks;
    t_stall;
    t_ignore;
    t_idle;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule